// File: doc/BRIEF.md
# Per-Channel Color Matrix Transform

This block applies a 3x3 color matrix to RGB pixels on their way to the gamma lookup stage of a display compositor. Each incoming pixel carries the tag of the display channel that produced it. Only one channel at a time can use the matrix. Pixels from every other channel pass through unchanged. When the matrix is switched off, all pixels pass through. Both paths have the same three-cycle latency, so the output order always matches the input order.

Software writes three coefficient words and one control word through a simple write port. These writes go into shadow registers. The live settings load from the shadow copy only when a frame-boundary strobe arrives, so no frame is ever processed with a mix of old and new settings. Each coefficient is sign-magnitude with a sign bit and a purely fractional magnitude, and has no integer bits. Each output component is the sum of the three input components, each weighted by its coefficient. The sum is rounded to the nearest integer and clamped to the pixel range. Pixels move through the pipeline with a valid/ready handshake.

Top module: `chan_color_matrix`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, the live channel selector is 0 (transform off) and all live coefficients are zero.
- R2: For a pixel being transformed, each output component equals R·c(R→X) + G·c(G→X) + B·c(B→X). A 10-bit coefficient c has its sign in bit 9 (1 means negative) and a magnitude of bits 8:0 divided by 512.
- R3: The weighted sum, in units of 1/512, has 256 added and is then shifted right arithmetically by 9, so halves round upward. The result is clamped to the range 0 to 255.
- R4: The input component selects the coefficient word: address 2 holds the red-input terms, address 1 the green-input terms and address 0 the blue-input terms. Within a word, the term feeding output R sits at bits 9:0, output G at bits 19:10 and output B at bits 29:20.
- R5: Address 3 is the control word, with the channel selector in bits 2:0. A selector of 0 turns the transform off. A selector of n transforms only pixels whose tag is n-1. All other pixels leave with their components and tag unchanged.
- R6: A selector value above the number of channels (5 to 7 with 4 channels) matches no tag, so every pixel passes through.
- R7: A register write has no effect on output pixels until a frame strobe arrives. At that strobe edge, the live settings take the shadow values written before that edge. A write in the same cycle as a strobe takes effect only at the next strobe.
- R8: With out_ready held high, a pixel accepted at one clock edge appears on the outputs after the third edge, counting the accepting edge as the first. Pixels leave in the order they were accepted.
- R9: While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low.
- R10: Bits 31:30 of a coefficient word, and bits 31:3 of the control word, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address: 0 blue-input terms, 1 green-input terms, 2 red-input terms, 3 control |
| cfg_wdata | input | 32 | Register write data |
| frame_strobe | input | 1 | Frame boundary; loads the shadow settings into the live settings |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_chan | input | 2 | Display channel tag of the input pixel |
| in_r | input | 8 | Input red |
| in_g | input | 8 | Input green |
| in_b | input | 8 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can accept the output pixel |
| out_chan | output | 2 | Channel tag of the output pixel |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |

## Verification
The hardest case to reach is a frame strobe that lands while pixels are in flight and out_ready is toggling. Each pixel must use the settings that were live in the cycle it was accepted, even though new settings load before it leaves. The stimulus strobes at random cycles, often in the same cycle as a register write or an accepted pixel, while out_ready is driven at random. The reference model captures the live settings at the moment each pixel is accepted. Directed cases cover:
- a clean latency count;
- exact rounding ties;
- full-scale positive and negative clamping;
- selectors above the channel count;
- writes that set the reserved bits.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

   localparam int NUM_COMP = 3;

   typedef enum logic [1:0] {
      CFG_BLUE_IN  = 2'd0,
      CFG_GREEN_IN = 2'd1,
      CFG_RED_IN   = 2'd2,
      CFG_CTRL     = 2'd3
   } cfg_addr_e;

endpackage

// File: rtl/cmx_cfg_bank.sv
module cmx_cfg_bank
   import cmx_pkg::*;
#(
   parameter int COEF_W = 10,
   parameter int SEL_W  = 3,
   parameter int WORD_W = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [1:0]                            wr_addr,
   input  logic [WORD_W-1:0]                     wr_data,
   input  logic                                  frame_strobe,
   output logic [NUM_COMP-1:0][NUM_COMP-1:0][COEF_W-1:0] act_coef,
   output logic [SEL_W-1:0]                      act_sel
);

   localparam int FIELDS_W = NUM_COMP * COEF_W;

   if (FIELDS_W > WORD_W) begin : g_bad_word
      $error("cmx_cfg_bank: coefficient fields do not fit in a word");
   end
   if (SEL_W > WORD_W) begin : g_bad_sel
      $error("cmx_cfg_bank: selector does not fit in a word");
   end

   logic [NUM_COMP-1:0][FIELDS_W-1:0] shd_word, act_word;
   logic [SEL_W-1:0]                  shd_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_word <= '0;
         shd_sel  <= '0;
         act_word <= '0;
         act_sel  <= '0;
      end else begin
         if (frame_strobe) begin
            act_word <= shd_word;
            act_sel  <= shd_sel;
         end
         if (wr_en) begin
            if (wr_addr == CFG_CTRL)
               shd_sel <= wr_data[SEL_W-1:0];
            else
               shd_word[wr_addr] <= wr_data[FIELDS_W-1:0];
         end
      end
   end

   // input component i (0=R,1=G,2=B) lives in word 2-i; output j at field j
   for (genvar i = 0; i < NUM_COMP; i++) begin : g_in
      for (genvar j = 0; j < NUM_COMP; j++) begin : g_out
         assign act_coef[i][j] = act_word[NUM_COMP-1-i][j*COEF_W +: COEF_W];
      end
   end

endmodule

// File: rtl/cmx_dot.sv
module cmx_dot
   import cmx_pkg::*;
#(
   parameter int PIX_W         = 8,
   parameter int COEF_W        = 10,
   parameter bit ROUND_NEAREST = 1'b1,
   localparam int SUM_W        = PIX_W + COEF_W + 2
) (
   input  logic                                 clk,
   input  logic                                 en,
   input  logic [NUM_COMP-1:0][PIX_W-1:0]       pix,
   input  logic [NUM_COMP-1:0][COEF_W-1:0]      coef,
   output logic signed [SUM_W-1:0]              res
);

   localparam int FRAC   = COEF_W - 1;
   localparam int PROD_W = PIX_W + COEF_W;

   if (COEF_W < 3) begin : g_bad_coef
      $error("cmx_dot: coefficient width too small");
   end

   logic [NUM_COMP-1:0][PROD_W-2:0]          umul;
   logic signed [PROD_W-1:0]                 sprod [NUM_COMP];
   logic signed [PROD_W-1:0]                 prod_q [NUM_COMP];
   logic signed [SUM_W-1:0]                  rnd_k;
   logic signed [SUM_W-1:0]                  sum_c;

   for (genvar i = 0; i < NUM_COMP; i++) begin : g_mul
      assign umul[i]  = {{FRAC{1'b0}}, pix[i]} * {{PIX_W{1'b0}}, coef[i][FRAC-1:0]};
      assign sprod[i] = coef[i][FRAC] ? -$signed({1'b0, umul[i]})
                                      :  $signed({1'b0, umul[i]});
   end

   if (ROUND_NEAREST) begin : g_round
      assign rnd_k = SUM_W'(1) <<< (FRAC - 1);
   end else begin : g_trunc
      assign rnd_k = '0;
   end

   always_comb begin
      sum_c = rnd_k;
      for (int i = 0; i < NUM_COMP; i++)
         sum_c = sum_c + $signed({{2{prod_q[i][PROD_W-1]}}, prod_q[i]});
   end

   always_ff @(posedge clk) begin
      if (en) begin
         for (int i = 0; i < NUM_COMP; i++) prod_q[i] <= sprod[i];
         res <= sum_c >>> FRAC;
      end
   end

endmodule

// File: rtl/chan_color_matrix.sv
module chan_color_matrix
   import cmx_pkg::*;
#(
   parameter int PIX_W         = 8,
   parameter int COEF_W        = 10,
   parameter int CHAN_W        = 2,
   parameter int WORD_W        = 32,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              frame_strobe,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CHAN_W-1:0] in_chan,
   input  logic [PIX_W-1:0]  in_r,
   input  logic [PIX_W-1:0]  in_g,
   input  logic [PIX_W-1:0]  in_b,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [CHAN_W-1:0] out_chan,
   output logic [PIX_W-1:0]  out_r,
   output logic [PIX_W-1:0]  out_g,
   output logic [PIX_W-1:0]  out_b
);

   localparam int SEL_W = CHAN_W + 1;
   localparam int SUM_W = PIX_W + COEF_W + 2;
   localparam int DEPTH = 3;

   if (CHAN_W < 1) begin : g_bad_chan
      $error("chan_color_matrix: need at least one channel bit");
   end

   logic [NUM_COMP-1:0][NUM_COMP-1:0][COEF_W-1:0] act_coef;
   logic [SEL_W-1:0]                              act_sel;

   cmx_cfg_bank #(.COEF_W(COEF_W), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_cfg (
      .clk, .rst_n,
      .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
      .frame_strobe,
      .act_coef, .act_sel
   );

   logic                            adv;
   logic [DEPTH-1:0]                vld;
   logic [NUM_COMP-1:0][PIX_W-1:0]  pix_in;
   logic                            apply_in;
   logic [NUM_COMP-1:0][PIX_W-1:0]  pix_d [DEPTH-1];
   logic [CHAN_W-1:0]               chan_d [DEPTH-1];
   logic [DEPTH-2:0]                app_d;
   logic signed [SUM_W-1:0]         res [NUM_COMP];
   logic [NUM_COMP-1:0][PIX_W-1:0]  out_q;
   logic [CHAN_W-1:0]               out_chan_q;

   assign adv      = !vld[DEPTH-1] || out_ready;
   assign in_ready = adv;
   assign pix_in   = {in_b, in_g, in_r};
   assign apply_in = (act_sel != '0) && ({1'b0, in_chan} == act_sel - SEL_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else if (adv) vld <= {vld[DEPTH-2:0], in_valid};
   end

   for (genvar j = 0; j < NUM_COMP; j++) begin : g_col
      logic [NUM_COMP-1:0][COEF_W-1:0] col;
      for (genvar i = 0; i < NUM_COMP; i++) begin : g_row
         assign col[i] = act_coef[i][j];
      end
      cmx_dot #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ROUND_NEAREST(ROUND_NEAREST)) u_dot (
         .clk, .en(adv), .pix(pix_in), .coef(col), .res(res[j])
      );
   end

   function automatic logic [PIX_W-1:0] clamp_pix(input logic signed [SUM_W-1:0] v);
      if (v[SUM_W-1])               return '0;
      else if (|v[SUM_W-2:PIX_W])   return '1;
      else                          return v[PIX_W-1:0];
   endfunction

   always_ff @(posedge clk) begin
      if (adv) begin
         pix_d[0]  <= pix_in;
         chan_d[0] <= in_chan;
         app_d[0]  <= apply_in;
         for (int s = 1; s < DEPTH-1; s++) begin
            pix_d[s]  <= pix_d[s-1];
            chan_d[s] <= chan_d[s-1];
            app_d[s]  <= app_d[s-1];
         end
         for (int j = 0; j < NUM_COMP; j++)
            out_q[j] <= app_d[DEPTH-2] ? clamp_pix(res[j]) : pix_d[DEPTH-2][j];
         out_chan_q <= chan_d[DEPTH-2];
      end
   end

   assign out_valid = vld[DEPTH-1];
   assign out_chan  = out_chan_q;
   assign out_r     = out_q[0];
   assign out_g     = out_q[1];
   assign out_b     = out_q[2];

endmodule

// File: rtl/cmx_check.sv
module cmx_check
   import cmx_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 10,
   parameter int CHAN_W = 2
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  frame_strobe,
   input logic                                  in_ready,
   input logic                                  out_valid,
   input logic                                  out_ready,
   input logic [CHAN_W-1:0]                     out_chan,
   input logic [PIX_W-1:0]                      out_r,
   input logic [PIX_W-1:0]                      out_g,
   input logic [PIX_W-1:0]                      out_b,
   input logic [NUM_COMP-1:0][NUM_COMP-1:0][COEF_W-1:0] act_coef,
   input logic [CHAN_W:0]                       act_sel
);

   // R1: first cycle out of reset has an empty pipeline and an open input
   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));

   // R9: a stalled output holds its contents
   a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g)
                                     && $stable(out_b) && $stable(out_chan)));

   // R9: a stalled output blocks new input
   a_r9_block_input: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R7: live settings change only at a frame strobe edge
   a_r7_frame_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_strobe) |-> ($stable(act_coef) && $stable(act_sel)));

endmodule

bind chan_color_matrix cmx_check #(.PIX_W(PIX_W), .COEF_W(COEF_W), .CHAN_W(CHAN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
   .out_r(out_r), .out_g(out_g), .out_b(out_b),
   .act_coef(act_coef), .act_sel(act_sel)
);

// File: tb/chan_color_matrix_test.sv
module chan_color_matrix_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        frame_strobe = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_chan = '0;
   logic [7:0]  in_r = '0, in_g = '0, in_b = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [1:0]  out_chan;
   logic [7:0]  out_r, out_g, out_b;

   always #2 clk = ~clk;

   chan_color_matrix uut (.*);

   typedef struct {
      int r, g, b, ch, acc;
      string tag;
   } exp_t;

   exp_t    exp_q[$];
   int      errors = 0, checks = 0, cyc = 0;
   bit      done = 1'b0;
   bit      lat_chk = 1'b0;
   logic [31:0] m_shd[3], m_act[3];
   int      m_shd_sel = 0, m_act_sel = 0;
   bit      stalled = 1'b0;
   int      held[4];

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int cval(input logic [31:0] w, input int f);
      logic [9:0] c;
      c = w[f*10 +: 10];
      return c[9] ? -int'(c[8:0]) : int'(c[8:0]);
   endfunction

   // R2 R3 R4 R5 R6: reference model from live settings at acceptance
   function automatic exp_t model(input int r, g, b, ch, input string tag);
      exp_t e;
      int pix[3], o[3];
      pix[0] = r; pix[1] = g; pix[2] = b;
      for (int j = 0; j < 3; j++) begin
         int s;
         s = 0;
         for (int i = 0; i < 3; i++) s += pix[i] * cval(m_act[2-i], j);
         s = (s + 256) >>> 9;
         o[j] = (s < 0) ? 0 : (s > 255) ? 255 : s;
      end
      if (m_act_sel != 0 && ch == m_act_sel - 1) begin
         e.r = o[0]; e.g = o[1]; e.b = o[2];
      end else begin
         e.r = r; e.g = g; e.b = b;
      end
      e.ch = ch; e.acc = cyc; e.tag = tag;
      return e;
   endfunction

   function automatic logic [31:0] pack(input logic [9:0] to_r, to_g, to_b, input logic [1:0] rsv);
      return {rsv, to_b, to_g, to_r};
   endfunction

   task automatic step(input bit iv, input int r, g, b, ch, input bit ordy,
                       input bit we, input int addr, input logic [31:0] data,
                       input bit fs, input string tag);
      @(negedge clk);
      in_valid = iv; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b); in_chan = 2'(ch);
      out_ready = ordy; cfg_we = we; cfg_addr = 2'(addr); cfg_wdata = data;
      frame_strobe = fs;
      #1;
      if (stalled) begin // R9
         check(out_valid && out_r == 8'(held[0]) && out_g == 8'(held[1]) &&
               out_b == 8'(held[2]) && out_chan == 2'(held[3]), "R9 hold",
               int'(out_r), held[0]);
      end
      if (out_valid && out_ready) begin
         if (exp_q.size() == 0) check(1'b0, "R8 unexpected output", 1, 0);
         else begin
            exp_t e;
            e = exp_q.pop_front();
            check(out_r == 8'(e.r), {e.tag, " red"},   int'(out_r), e.r);
            check(out_g == 8'(e.g), {e.tag, " green"}, int'(out_g), e.g);
            check(out_b == 8'(e.b), {e.tag, " blue"},  int'(out_b), e.b);
            check(out_chan == 2'(e.ch), {e.tag, " tag"}, int'(out_chan), e.ch);
            if (lat_chk) check(cyc - e.acc == 3, "R8 latency", cyc - e.acc, 3);
         end
      end
      if (out_valid && !out_ready) check(!in_ready, "R9 in_ready", int'(in_ready), 0);
      stalled = out_valid && !out_ready;
      held[0] = out_r; held[1] = out_g; held[2] = out_b; held[3] = out_chan;
      if (in_valid && in_ready) exp_q.push_back(model(r, g, b, ch, tag));
      if (fs) begin
         m_act = m_shd;
         m_act_sel = m_shd_sel;
      end
      if (we) begin
         if (addr == 3) m_shd_sel = int'(data[2:0]);
         else m_shd[addr] = {2'b00, data[29:0]};
      end
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "idle");
   endtask

   task automatic drain();
      for (int k = 0; k < 40 && exp_q.size() > 0; k++) idle(1);
      check(exp_q.size() == 0, "R8 drain", exp_q.size(), 0);
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      step(0, 0, 0, 0, 0, 1, 1, addr, data, 0, "cfg");
   endtask

   task automatic strobe();
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "strobe");
   endtask

   task automatic burst(input int n, input int chmask, input string tag);
      for (int k = 0; k < n; k++)
         step($urandom_range(0, 3) != 0, $urandom_range(0, 255), $urandom_range(0, 255),
              $urandom_range(0, 255), $urandom_range(0, 3) & chmask,
              $urandom_range(0, 2) != 0, 0, 0, 0, 0, tag);
      drain();
   endtask

   function automatic logic [9:0] rcoef();
      return 10'($urandom_range(0, 1023));
   endfunction

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < 3; i++) begin m_shd[i] = '0; m_act[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(!out_valid, "R1 out_valid", int'(out_valid), 0);
      check(in_ready, "R1 in_ready", int'(in_ready), 1);

      // R1 R8: zero coefficients but selector 0, so pass-through; latency count
      lat_chk = 1'b1;
      step(1, 12, 200, 77, 0, 1, 0, 0, 0, 0, "R1 R8 passthrough after reset");
      idle(5);
      lat_chk = 1'b0;
      drain();

      // R4 R5: a distinct coefficient per position, channel 1 selected
      wr(2, pack(10'h100, 10'h040, 10'h020, 2'b00));   // red input
      wr(1, pack(10'h010, 10'h100, 10'h208, 2'b00));   // green input
      wr(0, pack(10'h004, 10'h002, 10'h100, 2'b00));   // blue input
      wr(3, 32'd2);
      // R7: not live before strobe
      step(1, 100, 100, 100, 1, 1, 0, 0, 0, 0, "R7 before strobe");
      drain();
      strobe();
      step(1, 255, 0, 0, 1, 1, 0, 0, 0, 0, "R4 red column");
      step(1, 0, 255, 0, 1, 1, 0, 0, 0, 0, "R4 green column");
      step(1, 0, 0, 255, 1, 1, 0, 0, 0, 0, "R4 blue column");
      step(1, 50, 60, 70, 2, 1, 0, 0, 0, 0, "R5 other channel");
      drain();
      burst(120, 3, "R2 R5 R9 random");

      // R3: rounding tie and clamping
      wr(2, pack(10'h100, 10'h000, 10'h000, 2'b00));
      wr(1, pack(10'h000, 10'h000, 10'h000, 2'b00));
      wr(0, pack(10'h000, 10'h000, 10'h000, 2'b00));
      strobe();
      step(1, 1, 9, 9, 1, 1, 0, 0, 0, 0, "R3 tie rounds up");
      step(1, 3, 9, 9, 1, 1, 0, 0, 0, 0, "R3 tie 1.5");
      drain();
      wr(2, pack(10'h1FF, 10'h3FF, 10'h1FF, 2'b00));
      wr(1, pack(10'h1FF, 10'h3FF, 10'h1FF, 2'b00));
      wr(0, pack(10'h1FF, 10'h3FF, 10'h000, 2'b00));
      strobe();
      step(1, 255, 255, 255, 1, 1, 0, 0, 0, 0, "R3 clamp high and low");
      step(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, "R3 small value");
      drain();

      // R10: reserved bits set, control upper bits set
      wr(2, pack(10'h080, 10'h000, 10'h000, 2'b11));
      wr(1, pack(10'h000, 10'h080, 10'h000, 2'b11));
      wr(0, pack(10'h000, 10'h000, 10'h080, 2'b11));
      wr(3, 32'hFFFF_FFF9);                           // selector field 1
      strobe();
      step(1, 200, 100, 50, 0, 1, 0, 0, 0, 0, "R10 reserved ignored");
      step(1, 200, 100, 50, 3, 1, 0, 0, 0, 0, "R10 other channel");
      drain();

      // R6: selector beyond channel count
      wr(3, 32'd6);
      strobe();
      burst(40, 3, "R6 no match");

      // R7: write and strobe in the same cycle, then random strobes mid-stream
      wr(3, 32'd4);
      step(0, 0, 0, 0, 0, 1, 1, 3, 32'd1, 1, "R7 same-cycle");
      step(1, 90, 80, 70, 3, 1, 0, 0, 0, 0, "R7 old shadow live");
      step(1, 90, 80, 70, 0, 1, 0, 0, 0, 0, "R7 new write pending");
      drain();
      for (int k = 0; k < 1500; k++) begin
         int a;
         a = $urandom_range(0, 3);
         step($urandom_range(0, 3) != 0, $urandom_range(0, 255), $urandom_range(0, 255),
              $urandom_range(0, 255), $urandom_range(0, 3), $urandom_range(0, 3) != 0,
              $urandom_range(0, 3) == 0, a,
              (a == 3) ? 32'($urandom_range(0, 7)) : pack(rcoef(), rcoef(), rcoef(), 2'($urandom)),
              $urandom_range(0, 15) == 0, "R7 R2 mixed random");
      end
      drain();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule